// File: doc/BRIEF.md
# Credit-Based Pulse Link Controller

This block carries a single-cycle pulse handshake across a long link. The link is built from plain pipeline registers, with a fixed number of stages in each direction. A requester on the sending end asks to send. The sender issues a one-cycle pulse toward the far end only while it holds credit. That pulse reaches the receiving end after the forward stages. When the receiving end finishes an item, it answers with a one-cycle pulse, and that pulse crosses the same number of return stages back to the sender.

Each end keeps a credit counter. The count starts at twice the stage count, so the whole round trip can be filled and the link runs at one pulse per clock despite the added latency. The sender spends one credit per issued pulse and regains one per returning pulse. The receiver mirrors this from its own view: arriving pulses lower its count and pulses it sends back raise it. A flag tells the requester whether the sender currently holds any credit.

The payload travels elsewhere. This block only manages the pulses and the credit accounting for that payload.

Top module: `credit_link`

## Requirements
- R1: While `rst` is high and in the first cycle after it, both credit counts read 2*STAGES, `tx_credit_ok_o` is 1, and `rx_pulse_o`, `tx_return_o` and `rx_sent_o` are 0.
- R2: `tx_fire_o` is 1 in a cycle exactly when `tx_req_i` is 1 and either the sender count is nonzero or `tx_return_o` is 1 in that same cycle. A request with no credit and no arriving return issues nothing.
- R3: On each clock edge the sender count falls by one for a fire without a return, rises by one for a return without a fire, and is unchanged when both or neither occur.
- R4: A pulse fired in cycle t shows on `rx_pulse_o` in cycle t+STAGES and in no other cycle.
- R5: `rx_sent_o` is 1 exactly when `rx_done_i` is 1 and the receiver holds an item, or an item is arriving on `rx_pulse_o` in that cycle. A pulse sent in cycle u shows on `tx_return_o` in cycle u+STAGES.
- R6: On each clock edge the receiver count falls by one for an arrival without a send-back, rises by one for a send-back without an arrival, and is unchanged otherwise.
- R7: `rx_done_i` is ignored while the receiver count is 2*STAGES and `rx_pulse_o` is 0. No return pulse is launched, and the receiver count stays at 2*STAGES.
- R8: `tx_credit_ok_o` is 1 exactly when the sender count read in the same cycle is nonzero.
- R9: With `tx_req_i` held at 1 and `rx_done_i` following `rx_pulse_o`, `tx_fire_o` stays at 1 in every cycle after reset.
- R10: Both counts stay within 0 to 2*STAGES at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_req_i | input | 1 | Sender wants to issue a pulse this cycle |
| tx_fire_o | output | 1 | Pulse issued this cycle (request granted) |
| tx_credit_ok_o | output | 1 | Sender count is nonzero |
| tx_credit_o | output | $clog2(2*STAGES+1) | Sender credit count |
| tx_return_o | output | 1 | Return pulse arriving at the sender |
| rx_pulse_o | output | 1 | Forward pulse arriving at the receiver |
| rx_done_i | input | 1 | Receiver finished an item |
| rx_sent_o | output | 1 | Return pulse launched this cycle |
| rx_credit_o | output | $clog2(2*STAGES+1) | Receiver credit count |

## Verification
The bench first drains every credit with the receiver silent. A design that let a request through at zero credit would drive the sender count below zero and wrap it. It then lets a return arrive in the same cycle as a request at zero credit. A design that only looked at the registered count would stall there, and R9's steady stream would show a gap. Completions are raised while the receiver holds nothing, which catches a design that launches phantom returns and pushes the counts above 2*STAGES. Random traffic then checks the arrival and return cycles against a bench model; an off-by-one in the stage count would show every pulse one cycle early or late.

// File: rtl/credit_link_pkg.sv
package credit_link_pkg;
  // Width of a counter that must hold 0 .. 2*stages
  function automatic int credit_width(input int stages);
    return $clog2(2 * stages + 1);
  endfunction
endpackage

// File: rtl/pulse_pipe.sv
module pulse_pipe #(
  parameter int STAGES = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic pulse_in,
  output logic pulse_out
);
  logic [STAGES-1:0] stage_q;

  always_ff @(posedge clk) begin
    if (rst) stage_q[0] <= 1'b0;
    else     stage_q[0] <= pulse_in;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage_q[g] <= 1'b0;
      else     stage_q[g] <= stage_q[g-1];
    end
  end

  assign pulse_out = stage_q[STAGES-1];
endmodule

// File: rtl/credit_counter.sv
module credit_counter #(
  parameter int LIMIT = 6,
  localparam int CW = $clog2(LIMIT + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          take,
  input  logic          give,
  output logic [CW-1:0] count,
  output logic          nonzero
);
  localparam logic [CW-1:0] FULL = CW'(LIMIT);

  logic [CW-1:0] count_d;

  always_comb begin
    count_d = count;
    if (take && !give)      count_d = count - 1'b1;
    else if (give && !take) count_d = count + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count   <= FULL;
      nonzero <= 1'b1;
    end else begin
      count   <= count_d;
      nonzero <= (count_d != '0);
    end
  end
endmodule

// File: rtl/credit_link.sv
module credit_link
  import credit_link_pkg::*;
#(
  parameter int STAGES = 3,
  localparam int LIMIT = 2 * STAGES,
  localparam int CW = credit_width(STAGES)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tx_req_i,
  output logic          tx_fire_o,
  output logic          tx_credit_ok_o,
  output logic [CW-1:0] tx_credit_o,
  output logic          tx_return_o,
  output logic          rx_pulse_o,
  input  logic          rx_done_i,
  output logic          rx_sent_o,
  output logic [CW-1:0] rx_credit_o
);
  localparam logic [CW-1:0] FULL = CW'(LIMIT);

  logic rx_holding;

  // A returning credit may be spent in the cycle it arrives
  assign tx_fire_o  = tx_req_i && (tx_credit_ok_o || tx_return_o);
  // Receiver holds an item when its count is below full
  assign rx_holding = (rx_credit_o != FULL);
  assign rx_sent_o  = rx_done_i && (rx_holding || rx_pulse_o);

  credit_counter #(.LIMIT(LIMIT)) tx_cnt_i (
    .clk(clk), .rst(rst),
    .take(tx_fire_o), .give(tx_return_o),
    .count(tx_credit_o), .nonzero(tx_credit_ok_o)
  );

  logic rx_nonzero_unused;
  credit_counter #(.LIMIT(LIMIT)) rx_cnt_i (
    .clk(clk), .rst(rst),
    .take(rx_pulse_o), .give(rx_sent_o),
    .count(rx_credit_o), .nonzero(rx_nonzero_unused)
  );

  pulse_pipe #(.STAGES(STAGES)) fwd_pipe_i (
    .clk(clk), .rst(rst), .pulse_in(tx_fire_o), .pulse_out(rx_pulse_o)
  );

  pulse_pipe #(.STAGES(STAGES)) ret_pipe_i (
    .clk(clk), .rst(rst), .pulse_in(rx_sent_o), .pulse_out(tx_return_o)
  );
endmodule

// File: rtl/credit_link_chk.sv
module credit_link_chk #(
  parameter int STAGES = 3,
  localparam int CW = $clog2(2 * STAGES + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          tx_fire_o,
  input logic          tx_return_o,
  input logic [CW-1:0] tx_credit_o,
  input logic          rx_pulse_o,
  input logic          rx_done_i,
  input logic          rx_sent_o,
  input logic [CW-1:0] rx_credit_o
);
  localparam int LIMIT = 2 * STAGES;

  // R10
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    int'(tx_credit_o) <= LIMIT);

  // R10
  rx_range_chk: assert property (@(posedge clk) disable iff (rst)
    int'(rx_credit_o) <= LIMIT);

  // R2
  fire_credit_chk: assert property (@(posedge clk) disable iff (rst)
    tx_fire_o |-> (tx_credit_o != '0 || tx_return_o));

  // R3
  tx_spend_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_fire_o && !tx_return_o) |=> (tx_credit_o == $past(tx_credit_o) - 1'b1));

  // R7
  rx_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (int'(rx_credit_o) == LIMIT && !rx_pulse_o && rx_done_i) |-> !rx_sent_o);
endmodule

bind credit_link credit_link_chk #(.STAGES(STAGES)) chk_i (
  .clk(clk), .rst(rst),
  .tx_fire_o(tx_fire_o), .tx_return_o(tx_return_o), .tx_credit_o(tx_credit_o),
  .rx_pulse_o(rx_pulse_o), .rx_done_i(rx_done_i), .rx_sent_o(rx_sent_o),
  .rx_credit_o(rx_credit_o)
);

// File: tb/credit_link_tb_top.sv
module credit_link_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N = 3;
  localparam int LIM = 2 * N;
  localparam int CW = $clog2(2 * N + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tx_req_i = 1'b0;
  logic rx_done_i = 1'b0;
  logic tx_fire_o, tx_credit_ok_o, tx_return_o, rx_pulse_o, rx_sent_o;
  logic [CW-1:0] tx_credit_o, rx_credit_o;

  int checks = 0;
  int fails = 0;

  // bench model state
  bit fwd_m[N];
  bit ret_m[N];
  int tx_m = LIM;
  int rx_m = LIM;

  always #(CLK_PERIOD / 2) clk = ~clk;

  credit_link #(.STAGES(N)) dut_i (
    .clk(clk), .rst(rst),
    .tx_req_i(tx_req_i), .tx_fire_o(tx_fire_o), .tx_credit_ok_o(tx_credit_ok_o),
    .tx_credit_o(tx_credit_o), .tx_return_o(tx_return_o),
    .rx_pulse_o(rx_pulse_o), .rx_done_i(rx_done_i), .rx_sent_o(rx_sent_o),
    .rx_credit_o(rx_credit_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
    end
  endtask

  function automatic bit exp_fire(input bit req);
    return req && (tx_m > 0 || ret_m[N-1]);
  endfunction

  function automatic bit exp_sent(input bit done);
    return done && (rx_m < LIM || fwd_m[N-1]);
  endfunction

  // One cycle: drive at negedge, compare, advance model to next edge
  task automatic step(input bit req, input bit done);
    bit f, s;
    @(negedge clk);
    tx_req_i  = req;
    rx_done_i = done;
    #1;
    f = exp_fire(req);
    s = exp_sent(done);
    chk("R2 tx_fire", int'(tx_fire_o), int'(f));
    chk("R3 tx_credit", int'(tx_credit_o), tx_m);
    chk("R8 credit_ok", int'(tx_credit_ok_o), int'(tx_m != 0));
    chk("R4 rx_pulse", int'(rx_pulse_o), int'(fwd_m[N-1]));
    chk("R5 tx_return", int'(tx_return_o), int'(ret_m[N-1]));
    chk("R5 rx_sent", int'(rx_sent_o), int'(s));
    chk("R6 rx_credit", int'(rx_credit_o), rx_m);
    tx_m = tx_m - int'(f) + int'(ret_m[N-1]);
    rx_m = rx_m - int'(fwd_m[N-1]) + int'(s);
    for (int i = N - 1; i > 0; i--) begin
      fwd_m[i] = fwd_m[i-1];
      ret_m[i] = ret_m[i-1];
    end
    fwd_m[0] = f;
    ret_m[0] = s;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'd2024);
    for (int i = 0; i < N; i++) begin fwd_m[i] = 0; ret_m[i] = 0; end
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 tx_credit", int'(tx_credit_o), LIM);
    chk("R1 rx_credit", int'(rx_credit_o), LIM);
    chk("R1 credit_ok", int'(tx_credit_ok_o), 1);
    chk("R1 rx_pulse", int'(rx_pulse_o), 0);
    chk("R1 tx_return", int'(tx_return_o), 0);
    rst = 1'b0;
    #1;
    chk("R1 rx_sent", int'(rx_sent_o), 0);

    // R7: completion while receiver holds nothing
    repeat (4) begin
      step(1'b0, 1'b1);
      chk("R7 rx_credit full", int'(rx_credit_o), LIM);
    end

    // single pulse, receiver silent: arrival after N cycles (R4)
    step(1'b1, 1'b0);
    repeat (N + 2) step(1'b0, 1'b0);
    // drain all credit, receiver silent (R2, R8)
    repeat (LIM + 4) step(1'b1, 1'b0);
    chk("R2 blocked at zero", int'(tx_fire_o), 0);
    chk("R8 credit_ok low", int'(tx_credit_ok_o), 0);
    chk("R10 tx_credit zero", int'(tx_credit_o), 0);
    // receiver releases all held items, sender keeps requesting
    repeat (3 * LIM) step(1'b1, 1'b1);
    repeat (3 * LIM) step(1'b0, 1'b1);

    // R9: sustained stream with immediate completions
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < N; i++) begin fwd_m[i] = 0; ret_m[i] = 0; end
    tx_m = LIM;
    rx_m = LIM;
    for (int c = 0; c < 60; c++) begin
      step(1'b1, fwd_m[N-1]);
      chk("R9 sustained fire", int'(tx_fire_o), 1);
    end

    // random traffic
    for (int c = 0; c < 3000; c++) begin
      bit rq, dn;
      rq = ($urandom % 4) != 0;
      dn = ($urandom % 3) == 0;
      step(rq, dn);
      chk("R10 tx range", int'(tx_credit_o <= CW'(LIM)), 1);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule